// File: doc/BRIEF.md
# Delayed Pulse Generator

This block turns the rising edge of a slow, asynchronous trigger input into a single pulse. The pulse appears a fixed number of clock periods later and lasts a set number of clock periods. The trigger is first brought into the clock domain by a two-flop synchronizer. An edge detector then picks out its low-to-high transitions.

An edge seen while the block is idle arms it. While armed, a delay counter runs. When the delay count expires, a second timing stage drives the output high for the width count, and the block then disarms itself. Only the edge starts the sequence, so a trigger that drops long before the delay ends still gets its pulse.

Delay and width are separate count parameters. The timing is trimmed either by the counts or by the clock rate. With a clock near 8 Hz, the default counts of 8 and 1 give roughly one second of delay and a pulse of about 125 ms. Rising edges that arrive before the block has returned to idle are dropped.

Top module: `pdly_top`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes idle and `pulse_o` is low after that edge. Reset is synchronous and active high.
- R2: Only a low-to-high change of the synchronized trigger starts a cycle. A trigger held high for any length of time starts exactly one cycle.
- R3: If `trig_i` is first sampled high at clock edge k, the arming edge is k+2, and `pulse_o` goes high at edge k+2+DELAY_CYCLES.
- R4: `pulse_o` stays high for exactly WIDTH_CYCLES clock periods. It falls on the edge at which the block returns to idle.
- R5: A trigger pulse of two clock periods, which is shorter than the delay, is enough to produce the full output pulse.
- R6: A rising edge whose arming edge falls while the block is delaying or pulsing is ignored. This includes an arming edge that coincides with the falling edge of `pulse_o`. An edge one clock later starts a new cycle.
- R7: A reset asserted during the delay abandons the cycle, and no pulse is produced.
- R8: DELAY_CYCLES and WIDTH_CYCLES, each at least 1, set the delay and the width independently. Their defaults are 8 and 1.
- R9: `pulse_o` is driven straight from a flip-flop and changes only at clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous trigger; its rising edge starts a cycle |
| pulse_o | output | 1 | Registered delayed output pulse |

## Verification
Two functions can fall in the same cycle: the pulse stage finishing and returning to idle, and a new synchronized trigger edge trying to arm the block. The bench times a trigger so that its arming edge lands exactly on the falling edge of `pulse_o`, and expects no new pulse. It then repeats the trigger one clock later and expects a pulse at the exact predicted edge. A scoreboard models the acceptance window independently for two instances with different counts, and every unexpected or missing pulse is reported.

// File: rtl/pdly_pkg.sv
package pdly_pkg;

    // Number of flops in the trigger synchronizer.
    localparam int SYNC_STAGES = 2;

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } pdly_state_e;

    // Bits needed to count 0..n-1, never less than one.
    function automatic int cnt_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pdly_sync.sv
module pdly_sync #(
    parameter int STAGES = pdly_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pdly_edge.sv
module pdly_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b0;
        end else begin
            last_q <= level_i;
        end
    end

    assign rise_o = level_i & ~last_q;
endmodule

// File: rtl/pdly_ctrl.sv
module pdly_ctrl
    import pdly_pkg::*;
#(
    parameter int DELAY_CYCLES = 8,
    parameter int WIDTH_CYCLES = 1,
    parameter int DLY_W = cnt_bits(DELAY_CYCLES),
    parameter int WID_W = cnt_bits(WIDTH_CYCLES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_i,
    output pdly_state_e       state_o,
    output logic [DLY_W-1:0]  dcnt_o,
    output logic              pulse_o
);
    localparam logic [DLY_W-1:0] D_LAST = DLY_W'(DELAY_CYCLES - 1);
    localparam logic [WID_W-1:0] W_LAST = WID_W'(WIDTH_CYCLES - 1);

    pdly_state_e      state_q;
    logic [DLY_W-1:0] dcnt_q;
    logic [WID_W-1:0] wcnt_q;
    logic             pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dcnt_q  <= '0;
            wcnt_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (rise_i) begin
                        state_q <= ST_DELAY;
                        dcnt_q  <= '0;
                    end
                end
                ST_DELAY: begin
                    if (dcnt_q == D_LAST) begin
                        state_q <= ST_PULSE;
                        wcnt_q  <= '0;
                        pulse_q <= 1'b1;
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (wcnt_q == W_LAST) begin
                        state_q <= ST_IDLE;
                        dcnt_q  <= '0;
                        pulse_q <= 1'b0;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    pulse_q <= 1'b0;
                end
            endcase
        end
    end

    assign state_o = state_q;
    assign dcnt_o  = dcnt_q;
    assign pulse_o = pulse_q;
endmodule

// File: rtl/pdly_top.sv
module pdly_top
    import pdly_pkg::*;
#(
    parameter int DELAY_CYCLES = 8,
    parameter int WIDTH_CYCLES = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int DLY_W = cnt_bits(DELAY_CYCLES);
    localparam int WID_W = cnt_bits(WIDTH_CYCLES);

    logic             trig_sync;
    logic             trig_rise;
    pdly_state_e      ctl_state;
    logic [DLY_W-1:0] dly_cnt;

    pdly_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst     (rst),
        .async_i (trig_i),
        .sync_o  (trig_sync)
    );

    pdly_edge edge_i (
        .clk     (clk),
        .rst     (rst),
        .level_i (trig_sync),
        .rise_o  (trig_rise)
    );

    pdly_ctrl #(
        .DELAY_CYCLES (DELAY_CYCLES),
        .WIDTH_CYCLES (WIDTH_CYCLES),
        .DLY_W        (DLY_W),
        .WID_W        (WID_W)
    ) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (trig_rise),
        .state_o (ctl_state),
        .dcnt_o  (dly_cnt),
        .pulse_o (pulse_o)
    );
endmodule

// File: rtl/pdly_chk.sv
module pdly_chk
    import pdly_pkg::*;
#(
    parameter int DELAY_CYCLES = 8,
    parameter int WIDTH_CYCLES = 1,
    parameter int DLY_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             rise,
    input pdly_state_e      state,
    input logic [DLY_W-1:0] dcnt,
    input logic             pulse_o
);
    logic [31:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= '0;
        end else if (pulse_o) begin
            hi_cnt <= hi_cnt + 1;
        end else begin
            hi_cnt <= '0;
        end
    end

    // R1: reset leaves the block idle with the output low
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (state == ST_IDLE) && !pulse_o);

    // R2: the idle phase is left only on a detected edge
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && !rise |=> (state == ST_IDLE));

    // R2: a detected edge in idle arms the delay with a fresh count
    a_r2_arm: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) && rise |=> (state == ST_DELAY) && (dcnt == '0));

    // R3: the output rises only when the delay phase ends
    a_r3_rise_from_delay: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> ($past(state) == ST_DELAY) && (state == ST_PULSE));

    // R4: the output never stays high longer than the width
    a_r4_width_max: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> (hi_cnt < WIDTH_CYCLES));

    // R4: the output falls after exactly the width, back to idle
    a_r4_width_exact: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_o) && !$past(rst) |-> (hi_cnt == WIDTH_CYCLES) && (state == ST_IDLE));

    // R6: an edge during the pulse phase cannot re-arm
    a_r6_ignore_pulse: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PULSE) && rise |=> (state != ST_DELAY));

    // R6: an edge during the delay phase cannot restart the count
    a_r6_ignore_delay: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DELAY) && rise && (DELAY_CYCLES > 1) |=> (dcnt != '0) || (state != ST_DELAY));
endmodule

bind pdly_top pdly_chk #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .WIDTH_CYCLES (WIDTH_CYCLES),
    .DLY_W        (DLY_W)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .rise    (trig_rise),
    .state   (ctl_state),
    .dcnt    (dly_cnt),
    .pulse_o (pulse_o)
);

// File: tb/pdly_top_tb_top.sv
module pdly_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DA = 8;
    localparam int WA = 1;
    localparam int DB = 3;
    localparam int WB = 4;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig = 1'b0;
    logic pa, pb;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int exp_a[$];
    int exp_b[$];
    int end_a = 0;
    int end_b = 0;
    int rise_a = 0;
    int rise_b = 0;
    int cnt_a = 0;
    int cnt_b = 0;
    logic pa_prev = 1'b0;
    logic pb_prev = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pdly_top dut_i (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .pulse_o (pa)
    );

    pdly_top #(.DELAY_CYCLES(DB), .WIDTH_CYCLES(WB)) dut_b_i (
        .clk     (clk),
        .rst     (rst),
        .trig_i  (trig),
        .pulse_o (pb)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Driver: raise the trigger now, push the pulses the requirements predict.
    task automatic fire(input int hi, input int lo, input bit push);
        int arm;
        arm = cyc + 3;
        if (push && arm > end_a) begin
            exp_a.push_back(arm + DA);
            end_a = arm + DA + WA;
        end
        if (push && arm > end_b) begin
            exp_b.push_back(arm + DB);
            end_b = arm + DB + WB;
        end
        trig = 1'b1;
        wait_cyc(hi);
        trig = 1'b0;
        wait_cyc(lo);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (pa && !pa_prev) begin
            rise_a = cyc;
            cnt_a++;
        end
        if (!pa && pa_prev) begin
            if (exp_a.size() == 0) begin
                check(1'b0, "R6", "dut_a unexpected pulse at cycle", rise_a, -1);
            end else begin
                int e;
                e = exp_a.pop_front();
                check(rise_a == e, "R3", "dut_a pulse start cycle", rise_a, e);
                check(cyc - rise_a == WA, "R4", "dut_a pulse width", cyc - rise_a, WA);
            end
        end
        if (pb && !pb_prev) begin
            rise_b = cyc;
            cnt_b++;
        end
        if (!pb && pb_prev) begin
            if (exp_b.size() == 0) begin
                check(1'b0, "R6", "dut_b unexpected pulse at cycle", rise_b, -1);
            end else begin
                int e;
                e = exp_b.pop_front();
                check(rise_b == e, "R8", "dut_b pulse start cycle", rise_b, e);
                check(cyc - rise_b == WB, "R8", "dut_b pulse width", cyc - rise_b, WB);
            end
        end
        pa_prev = pa;
        pb_prev = pb;
    end

    // R9: output is registered, so it never moves on the falling edge
    always @(posedge clk) begin
        logic sa, sb;
        #(CLK_PERIOD/4);
        sa = pa;
        sb = pb;
        #(CLK_PERIOD/2);
        if (!rst && !done) begin
            if (pa !== sa || pb !== sb) begin
                check(1'b0, "R9", "output moved between clock edges", int'(pa), int'(sa));
            end
        end
    end

    initial begin
        int base_a, base_b;
        rst = 1'b1;
        wait_cyc(4);
        check(pa == 1'b0, "R1", "dut_a output during reset", int'(pa), 0);
        check(pb == 1'b0, "R1", "dut_b output during reset", int'(pb), 0);
        rst = 1'b0;
        wait_cyc(3);
        check(pa == 1'b0 && pb == 1'b0, "R1", "outputs after reset", int'(pa | pb), 0);

        // R5: short trigger, single pulse
        fire(2, 20, 1'b1);
        check(cnt_a == 1, "R5", "dut_a pulses after short trigger", cnt_a, 1);

        // R2: long high level yields one pulse only
        base_a = cnt_a; base_b = cnt_b;
        fire(30, 20, 1'b1);
        check(cnt_a - base_a == 1, "R2", "dut_a pulses for held trigger", cnt_a - base_a, 1);
        check(cnt_b - base_b == 1, "R2", "dut_b pulses for held trigger", cnt_b - base_b, 1);

        // R6: second edge during the delay is ignored
        base_a = cnt_a;
        fire(2, 2, 1'b1);
        fire(2, 20, 1'b1);
        check(cnt_a - base_a == 1, "R6", "dut_a pulses with edge during delay", cnt_a - base_a, 1);

        // R6: second edge arming on the output rise edge
        fire(2, 6, 1'b1);
        fire(2, 20, 1'b1);

        // R6: arming edge coincides with the falling edge: ignored
        base_a = cnt_a;
        fire(2, 7, 1'b1);
        fire(2, 20, 1'b1);
        check(cnt_a - base_a == 1, "R6", "dut_a pulses with edge on fall", cnt_a - base_a, 1);

        // R6: one clock later: accepted
        base_a = cnt_a;
        fire(2, 8, 1'b1);
        fire(2, 20, 1'b1);
        check(cnt_a - base_a == 2, "R6", "dut_a pulses with edge after fall", cnt_a - base_a, 2);

        // R7: reset in the middle of the delay
        base_a = cnt_a; base_b = cnt_b;
        fire(2, 2, 1'b0);
        rst = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        end_a = 0;
        end_b = 0;
        wait_cyc(20);
        check(cnt_a == base_a, "R7", "dut_a pulses after aborted cycle", cnt_a - base_a, 0);
        check(cnt_b == base_b, "R7", "dut_b pulses after aborted cycle", cnt_b - base_b, 0);

        // R3: normal operation resumes after the abort
        fire(3, 25, 1'b1);

        wait_cyc(30);
        check(exp_a.size() == 0, "R3", "dut_a missing pulses", exp_a.size(), 0);
        check(exp_b.size() == 0, "R8", "dut_b missing pulses", exp_b.size(), 0);
        check(pa == 1'b0 && pb == 1'b0, "R4", "outputs idle at end", int'(pa | pb), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3: actual %0d expected %0d", WATCHDOG, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule